// File: doc/BRIEF.md
# Up-Down Carrier PWM with Compare-Match Triggers

This block is one PWM channel that also sets the timing for an acquisition system. A signed counter starts at a programmable start value and counts up by one on each prescaled clock. When it reaches a terminal value it reloads the start value. If the start value is the negative of a half period, the period is symmetric around zero. Output A is high while the counter lies inside a programmable window, and output B is always its complement. Two trigger lines pulse when the counter enters the mid-cycle compare value and the terminal compare value. Each trigger has its own enable. The two triggers are also ORed onto a single line, which can start ADC conversions in step with the power stage twice per carrier period.

The five compare values (start, mid, terminal, window-on, window-off) are double-buffered. Writes land in a shadow set. A load request arms a transfer, and the transfer happens at the next reload point, so the active values never change in the middle of a period. A run input gates the counter and the prescaler.

Top module: `pwm_updown_trig`

## Requirements
- R1: After reset the counter holds -8 and the active and shadow compare sets are start=-8, mid=0, terminal=7, on=-4, off=4. The load request is not pending, all trigger outputs are low, `pwm_a` is low and `pwm_b` is high.
- R2: On each prescaled tick the counter rises by one. On the tick where it is at or above the terminal value it instead loads the start value, so one period lasts (terminal - start + 1) ticks.
- R3: A tick occurs once every 2^`prescale` clock cycles. The prescaler phase restarts when `run` is asserted, so the first tick comes 2^`prescale` cycles after `run` rises.
- R4: While `run` is low the counter and the prescaler hold their values and no trigger pulses.
- R5: `trig_mid` pulses high for exactly one clock cycle in the first cycle the counter shows the mid value, and only if `trig_en[0]` is set.
- R6: `trig_end` pulses high for exactly one clock cycle in the first cycle the counter shows the terminal value, and only if `trig_en[1]` is set.
- R7: `trig_any` is high exactly when `trig_mid` or `trig_end` is high.
- R8: A write with `cmp_wr` high stores `cmp_wdata` in the shadow value selected by `cmp_sel` (0 start, 1 mid, 2 terminal, 3 window-on, 4 window-off; codes 5 to 7 are ignored). Shadow values have no effect on counting, triggers or outputs until they are committed.
- R9: A `ldok_req` pulse sets `ldok_pending`, which stays high until the next reload tick. On that tick the whole shadow set becomes active, the counter reloads the new start value, and `ldok_pending` clears.
- R10: `pwm_a` is high when window-on <= counter < window-off (signed) and low otherwise. `pwm_b` is always the inverse of `pwm_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter and prescaler enable |
| prescale | input | PSC_W | Clock division exponent; a tick occurs every 2^prescale cycles |
| trig_en | input | 2 | Bit 0 enables the mid trigger, bit 1 enables the terminal trigger |
| cmp_wr | input | 1 | Shadow compare write strobe |
| cmp_sel | input | 3 | Shadow compare select |
| cmp_wdata | input | CNT_W | Signed shadow compare write data |
| ldok_req | input | 1 | Requests commit of the shadow set at the next reload |
| ldok_pending | output | 1 | A commit is armed and waiting for the reload point |
| count | output | CNT_W | Signed counter value |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | Complement of PWM output A |
| trig_mid | output | 1 | Mid compare trigger pulse |
| trig_end | output | 1 | Terminal compare trigger pulse |
| trig_any | output | 1 | OR of both trigger pulses |

## Verification
The main counting function is run in four patterns. The first is the default symmetric period at full clock rate with both triggers enabled, which measures the 16-cycle spacing between terminal triggers and the position of each pulse. The second uses divide-by-four, which separates the per-cycle pulse width from the slower counter steps. The third enables only the mid trigger, which shows that the enables act independently. The fourth writes a new shadow set, first without a commit and then with one, which shows the old period continuing until the reload point and then an 8-tick period with new mid, terminal and window values. A stopped interval between the patterns checks that the counter holds and that no pulses appear.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W  = 16;
    localparam int N_TRIG = 2;

    typedef logic signed [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_MID   = 3'd1,
        SEL_TERM  = 3'd2,
        SEL_ON    = 3'd3,
        SEL_OFF   = 3'd4
    } cmp_sel_e;

    typedef struct packed {
        cnt_t start_v;
        cnt_t mid_v;
        cnt_t term_v;
        cnt_t on_v;
        cnt_t off_v;
    } cmp_set_t;

    localparam cmp_set_t CMP_RST = '{
        start_v: cnt_t'(-8),
        mid_v:   cnt_t'(0),
        term_v:  cnt_t'(7),
        on_v:    cnt_t'(-4),
        off_v:   cnt_t'(4)
    };

    function automatic cmp_set_t put_field(cmp_set_t s, cmp_sel_e sel, cnt_t d);
        cmp_set_t r;
        r = s;
        case (sel)
            SEL_START: r.start_v = d;
            SEL_MID:   r.mid_v   = d;
            SEL_TERM:  r.term_v  = d;
            SEL_ON:    r.on_v    = d;
            SEL_OFF:   r.off_v   = d;
            default:   r = s;
        endcase
        return r;
    endfunction

    function automatic logic in_window(cnt_t c, cnt_t lo, cnt_t hi);
        return (c >= lo) && (c < hi);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] prescale,
    output logic             tick
);
    localparam int PCNT_W = (1 << PSC_W) - 1;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W:0]   span;
    logic [PCNT_W-1:0] limit;

    always_comb begin
        span  = ({{PCNT_W{1'b0}}, 1'b1} << prescale) - 1'b1;
        limit = span[PCNT_W-1:0];
    end

    assign tick = run && (pcnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  cmp_sel_e wr_sel,
    input  cnt_t     wr_data,
    input  logic     ldok_req,
    input  logic     wrap,
    output cmp_set_t shadow,
    output cmp_set_t active,
    output logic     pending,
    output logic     load
);
    assign load = pending && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= CMP_RST;
            active  <= CMP_RST;
            pending <= 1'b0;
        end else begin
            if (wr_en) begin
                shadow <= put_field(shadow, wr_sel, wr_data);
            end
            if (load) begin
                active <= shadow;
            end
            pending <= (pending && !wrap) || ldok_req;
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  cnt_t term_v,
    input  cnt_t reload_v,
    output cnt_t cnt,
    output logic wrap,
    output logic entered
);
    assign wrap = tick && (cnt >= term_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CMP_RST.start_v;
            entered <= 1'b0;
        end else begin
            entered <= tick;
            if (tick) begin
                cnt <= wrap ? reload_v : cnt_t'(cnt + cnt_t'(1));
            end
        end
    end
endmodule

// File: rtl/pwm_updown_trig.sv
module pwm_updown_trig
    import pwm_pkg::*;
#(
    parameter int PSC_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [PSC_W-1:0]        prescale,
    input  logic [N_TRIG-1:0]       trig_en,
    input  logic                    cmp_wr,
    input  logic [2:0]              cmp_sel,
    input  logic signed [CNT_W-1:0] cmp_wdata,
    input  logic                    ldok_req,
    output logic                    ldok_pending,
    output logic signed [CNT_W-1:0] count,
    output logic                    pwm_a,
    output logic                    pwm_b,
    output logic                    trig_mid,
    output logic                    trig_end,
    output logic                    trig_any
);
    logic     tick;
    logic     wrap;
    logic     load;
    logic     entered;
    cnt_t     cnt_q;
    cnt_t     reload_v;
    cmp_set_t shadow;
    cmp_set_t active;
    cnt_t     trig_ref [N_TRIG];
    logic [N_TRIG-1:0] trig_vec;

    pwm_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .prescale (prescale),
        .tick     (tick)
    );

    pwm_cmp_bank i_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmp_wr),
        .wr_sel   (cmp_sel_e'(cmp_sel)),
        .wr_data  (cmp_wdata),
        .ldok_req (ldok_req),
        .wrap     (wrap),
        .shadow   (shadow),
        .active   (active),
        .pending  (ldok_pending),
        .load     (load)
    );

    assign reload_v = load ? shadow.start_v : active.start_v;

    pwm_counter i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .term_v   (active.term_v),
        .reload_v (reload_v),
        .cnt      (cnt_q),
        .wrap     (wrap),
        .entered  (entered)
    );

    assign trig_ref[0] = active.mid_v;
    assign trig_ref[1] = active.term_v;

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        assign trig_vec[g] = entered && trig_en[g] && (cnt_q == trig_ref[g]);
    end

    assign trig_mid = trig_vec[0];
    assign trig_end = trig_vec[1];
    assign trig_any = |trig_vec;

    assign count = cnt_q;
    assign pwm_a = in_window(cnt_q, active.on_v, active.off_v);
    assign pwm_b = !pwm_a;
endmodule

// File: rtl/pwm_updown_trig_chk.sv
module pwm_updown_trig_chk
    import pwm_pkg::*;
#(
    parameter int PSC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [PSC_W-1:0] prescale,
    input cnt_t             count,
    input logic             trig_mid,
    input logic             trig_end,
    input logic             ldok_req,
    input logic             ldok_pending,
    input logic             wrap,
    input cmp_set_t         act
);
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count)); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) && (count != act.start_v)
            |-> count == cnt_t'($past(count) + cnt_t'(1))); // R2

    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (rst)
        run && (prescale != '0) && $stable(prescale) && (count != $past(count))
            |=> (prescale != $past(prescale)) || $stable(count)); // R3

    AST_MID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_mid && (prescale != '0) |=> !trig_mid); // R5

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_end && (prescale != '0) |=> !trig_end); // R6

    AST_LDOK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ldok_pending && wrap && !ldok_req |=> !ldok_pending); // R9

    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ldok_pending |=> $stable(act)); // R8
endmodule

bind pwm_updown_trig pwm_updown_trig_chk #(.PSC_W(PSC_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .prescale     (prescale),
    .count        (cnt_q),
    .trig_mid     (trig_mid),
    .trig_end     (trig_end),
    .ldok_req     (ldok_req),
    .ldok_pending (ldok_pending),
    .wrap         (wrap),
    .act          (active)
);

// File: tb/test_pwm_updown_trig.sv
module test_pwm_updown_trig;
    import pwm_pkg::*;

    localparam int PSC_W = 3;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    run = 1'b0;
    logic [PSC_W-1:0]        prescale = '0;
    logic [1:0]              trig_en = 2'b00;
    logic                    cmp_wr = 1'b0;
    logic [2:0]              cmp_sel = '0;
    logic signed [CNT_W-1:0] cmp_wdata = '0;
    logic                    ldok_req = 1'b0;
    logic                    ldok_pending;
    logic signed [CNT_W-1:0] count;
    logic                    pwm_a, pwm_b, trig_mid, trig_end, trig_any;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  last_end = -1;
    int  exp_period = 0;
    bit  done = 1'b0;

    typedef struct {
        bit is_end;
        int val;
    } exp_t;
    exp_t sb[$];

    pwm_updown_trig #(.PSC_W(PSC_W)) i_pwm_updown_trig (
        .clk(clk), .rst(rst), .run(run), .prescale(prescale), .trig_en(trig_en),
        .cmp_wr(cmp_wr), .cmp_sel(cmp_sel), .cmp_wdata(cmp_wdata), .ldok_req(ldok_req),
        .ldok_pending(ldok_pending), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .trig_mid(trig_mid), .trig_end(trig_end), .trig_any(trig_any)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(bit is_end, int val);
        exp_t e;
        e.is_end = is_end;
        e.val    = val;
        sb.push_back(e);
    endtask

    // monitor: pops expected trigger events as they appear
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(trig_any == (trig_mid || trig_end), "R7", "trig_any vs OR",
                trig_any, trig_mid || trig_end);
            if (trig_mid || trig_end) begin
                if (sb.size() == 0) begin
                    chk(1'b0, trig_end ? "R6" : "R5", "unexpected trigger at count",
                        int'(count), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(trig_end == e.is_end && trig_mid == !e.is_end,
                        e.is_end ? "R6" : "R5", "trigger kind (end=1)", trig_end, e.is_end);
                    chk(int'(count) == e.val, e.is_end ? "R6" : "R5",
                        "count at trigger", int'(count), e.val);
                end
                if (trig_end) begin
                    if (last_end >= 0 && exp_period > 0)
                        chk(cyc - last_end == exp_period, "R2", "terminal trigger spacing",
                            cyc - last_end, exp_period);
                    last_end = cyc;
                end
            end
        end
    end

    task automatic run_for(int n, bit pwm_chk, int on_v, int off_v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_chk) begin
                bit exp_a;
                exp_a = (int'(count) >= on_v) && (int'(count) < off_v);
                chk(pwm_a == exp_a, "R10", "pwm_a level", pwm_a, exp_a);
                chk(pwm_b == !exp_a, "R10", "pwm_b level", pwm_b, !exp_a);
            end
        end
    endtask

    task automatic write_reg(int sel, int val);
        @(negedge clk);
        cmp_wr    = 1'b1;
        cmp_sel   = 3'(sel);
        cmp_wdata = CNT_W'(val);
        @(negedge clk);
        cmp_wr    = 1'b0;
    endtask

    task automatic phase_end(string req);
        #2;
        chk(sb.size() == 0, req, "expected triggers left over", sb.size(), 0);
        sb.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(int'(count) == -8, "R1", "count after reset", int'(count), -8);
        chk(ldok_pending == 1'b0, "R1", "ldok_pending after reset", ldok_pending, 0);
        chk(trig_any == 1'b0, "R1", "trig_any after reset", trig_any, 0);
        chk(pwm_a == 1'b0 && pwm_b == 1'b1, "R1", "pwm_a/pwm_b after reset", {pwm_a, pwm_b}, 2'b01);

        // Pattern 1: full rate, both triggers (R2 R5 R6 R10)
        push(0, 0); push(1, 7); push(0, 0); push(1, 7);
        last_end = -1; exp_period = 16;
        @(negedge clk);
        trig_en = 2'b11; prescale = '0; run = 1'b1;
        run_for(36, 1'b1, -4, 4);
        run = 1'b0;
        chk(int'(count) == -4, "R2", "count after 36 ticks", int'(count), -4);
        phase_end("R2");

        // stopped: hold (R4)
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(int'(count) == -4, "R4", "count while stopped", int'(count), -4);
        end
        phase_end("R4");

        // Pattern 2: divide by 4 (R3)
        push(0, 0); push(1, 7);
        last_end = -1; exp_period = 0;
        @(negedge clk);
        prescale = 3'd2; run = 1'b1;
        begin
            int n1 = 0, n2 = 0;
            while (int'(count) == -4 && n1 < 20) begin @(negedge clk); n1++; end
            chk(n1 == 4, "R3", "cycles to first tick", n1, 4);
            while (int'(count) == -3 && n2 < 20) begin @(negedge clk); n2++; end
            chk(n2 == 4, "R3", "cycles between ticks", n2, 4);
            run_for(66 - n1 - n2, 1'b0, 0, 0);
        end
        run = 1'b0;
        chk(int'(count) == -4, "R3", "count after 16 slow ticks", int'(count), -4);
        phase_end("R3");

        // Pattern 3: only mid trigger enabled (R5 R6)
        push(0, 0);
        @(negedge clk);
        prescale = '0; trig_en = 2'b01; run = 1'b1;
        run_for(16, 1'b0, 0, 0);
        run = 1'b0;
        phase_end("R6");

        // Pattern 4: shadow writes without commit (R8)
        write_reg(0, -4);
        write_reg(1, -1);
        write_reg(2, 3);
        write_reg(3, -2);
        write_reg(4, 1);
        write_reg(6, 100);
        chk(ldok_pending == 1'b0, "R8", "pending after plain writes", ldok_pending, 0);
        push(0, 0); push(1, 7);
        @(negedge clk);
        trig_en = 2'b11; run = 1'b1;
        run_for(16, 1'b1, -4, 4);
        run = 1'b0;
        chk(int'(count) == -4, "R8", "count with uncommitted shadow", int'(count), -4);
        phase_end("R8");

        // commit (R9)
        @(negedge clk);
        ldok_req = 1'b1;
        @(negedge clk);
        ldok_req = 1'b0;
        chk(ldok_pending == 1'b1, "R9", "pending after request", ldok_pending, 1);
        push(0, 0); push(1, 7); push(0, -1); push(1, 3);
        exp_period = 0;
        run = 1'b1;
        run_for(12, 1'b0, 0, 0);
        chk(int'(count) == -4, "R9", "count after reload to new start", int'(count), -4);
        chk(ldok_pending == 1'b0, "R9", "pending after reload", ldok_pending, 0);
        run_for(8, 1'b0, 0, 0);
        phase_end("R9");
        push(0, -1); push(1, 3); push(0, -1); push(1, 3);
        last_end = -1; exp_period = 8;
        run_for(16, 1'b1, -2, 1);
        run = 1'b0;
        chk(int'(count) == -4, "R9", "count after two new periods", int'(count), -4);
        phase_end("R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule